// File: doc/BRIEF.md
# Branch condition evaluator

This block decides whether a conditional branch is taken and computes where it goes. For each branch it is given three things. The first is a four-bit flag vector, holding a two-bit relational code written by a compare instruction together with separate overflow and carry bits. The second is the four-bit condition field of the branch instruction. The third is the current program counter and the instruction's eight-bit offset.

A one-cycle evaluate strobe marks a branch in the decode stage. On the next clock edge the block registers a taken strobe and the 16-bit target address. When no evaluation is requested, the taken strobe stays low and the target register keeps its last value. The asynchronous active-low reset is released through an internal two-stage synchronizer.

Top module: `bce_top`

## Requirements
- R1: While reset is asserted, and after it is released until the first evaluation, `taken_o` is 0 and `target_o` is 0.
- R2: The flag vector carries the relational code in bits 3:2 (10 less, 01 equal, 00 greater), overflow in bit 1 and carry in bit 0. Condition 1000 is taken when the code is 10, condition 0100 when it is 01, and condition 0000 when it is 00.
- R3: Condition 1100 (less-or-equal) is taken when the relational code is 10 or 01, and is not taken for 00 or 11.
- R4: Condition 0010 is taken when overflow is set. Condition 0001 is taken when carry is set. Condition 0011 is taken only when both overflow and carry are set.
- R5: Condition 1111 is always taken, whatever the flags.
- R6: Every condition code not named in R2 to R5 is never taken.
- R7: One clock after `eval_i` is sampled high, `target_o` equals `pc_i + 1` plus the sign-extended offset, modulo 2^16, and `taken_o` gives the decision for the inputs sampled on that edge.
- R8: One clock after `eval_i` is sampled low, `taken_o` is 0 and `target_o` is unchanged, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_i | input | 1 | Evaluate strobe for a branch in decode |
| flags_i | input | 4 | Relational code [3:2], overflow [1], carry [0] |
| cond_i | input | 4 | Condition field of the branch instruction |
| pc_i | input | 16 | Current program counter |
| offset_i | input | 8 | Signed branch offset |
| taken_o | output | 1 | Registered taken strobe |
| target_o | output | 16 | Registered branch target |

## Verification
The hardest cases to reach from the ports are the ones that only a particular pairing of condition and flags exposes. Less-or-equal must be checked against the otherwise unused relational code 11, and overflow-and-carry must be checked against each bit set alone. The stimulus therefore sweeps all 256 pairings of condition field and flag vector with evaluation enabled. Between these evaluations it inserts idle cycles that carry changing inputs, which shows that the target is held. Separate address cases cover wrap at the top of memory and the largest negative and positive offsets.

// File: rtl/bce_pkg.sv
package bce_pkg;
  typedef enum logic [3:0] {
    COND_GT  = 4'b0000,
    COND_C   = 4'b0001,
    COND_V   = 4'b0010,
    COND_VC  = 4'b0011,
    COND_EQ  = 4'b0100,
    COND_LT  = 4'b1000,
    COND_LE  = 4'b1100,
    COND_ALL = 4'b1111
  } cond_code_e;

  typedef enum logic [2:0] {
    TST_NEVER,
    TST_REL,
    TST_LE,
    TST_OVF,
    TST_CRY,
    TST_BOTH,
    TST_ALWAYS
  } test_kind_e;

  typedef struct packed {
    logic [1:0] rel;
    logic       ovf;
    logic       cry;
  } flags_t;

  localparam logic [1:0] REL_LESS  = 2'b10;
  localparam logic [1:0] REL_EQUAL = 2'b01;
  localparam logic [1:0] REL_GREAT = 2'b00;
endpackage

// File: rtl/bce_rst_sync.sv
module bce_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bce_cond_decode.sv
module bce_cond_decode
  import bce_pkg::*;
(
  input  logic [3:0]  cond_i,
  output test_kind_e  kind_o,
  output logic [1:0]  rel_want_o
);
  always_comb begin
    kind_o     = TST_NEVER;
    rel_want_o = REL_GREAT;
    case (cond_i)
      COND_LT:  begin kind_o = TST_REL; rel_want_o = REL_LESS;  end
      COND_EQ:  begin kind_o = TST_REL; rel_want_o = REL_EQUAL; end
      COND_GT:  begin kind_o = TST_REL; rel_want_o = REL_GREAT; end
      COND_LE:  kind_o = TST_LE;
      COND_V:   kind_o = TST_OVF;
      COND_C:   kind_o = TST_CRY;
      COND_VC:  kind_o = TST_BOTH;
      COND_ALL: kind_o = TST_ALWAYS;
      default:  kind_o = TST_NEVER;
    endcase
  end
endmodule

// File: rtl/bce_flag_test.sv
module bce_flag_test
  import bce_pkg::*;
(
  input  test_kind_e kind_i,
  input  logic [1:0] rel_want_i,
  input  flags_t     flags_i,
  output logic       hit_o
);
  always_comb begin
    case (kind_i)
      TST_REL:    hit_o = (flags_i.rel == rel_want_i);
      TST_LE:     hit_o = (flags_i.rel == REL_LESS) || (flags_i.rel == REL_EQUAL);
      TST_OVF:    hit_o = flags_i.ovf;
      TST_CRY:    hit_o = flags_i.cry;
      TST_BOTH:   hit_o = flags_i.ovf & flags_i.cry;
      TST_ALWAYS: hit_o = 1'b1;
      default:    hit_o = 1'b0;
    endcase
  end

  // R3: less-or-equal never fires on greater
  always_comb begin
    if (kind_i == TST_LE && flags_i.rel == REL_GREAT)
      a_le_not_gt_r3: assert (!hit_o);
  end
endmodule

// File: rtl/bce_target_adder.sv
module bce_target_adder #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic [PC_W-1:0]  target_o
);
  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] off_ext;
  logic [PC_W-1:0] pc_next;

  always_comb begin
    off_ext  = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
    pc_next  = pc_i + {{(PC_W-1){1'b0}}, 1'b1};
    target_o = pc_next + off_ext;
  end
endmodule

// File: rtl/bce_top.sv
module bce_top
  import bce_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int OFF_W  = 8,
  parameter int COND_W = 4,
  parameter int FLAG_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic              taken_o,
  output logic [PC_W-1:0]   target_o
);
  logic            rst_sync_n;
  test_kind_e      kind;
  logic [1:0]      rel_want;
  logic            hit;
  logic [PC_W-1:0] target_calc;
  logic            taken_d, taken_q;
  logic [PC_W-1:0] target_d, target_q;

  bce_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bce_cond_decode u_dec (
    .cond_i     (cond_i),
    .kind_o     (kind),
    .rel_want_o (rel_want)
  );

  bce_flag_test u_tst (
    .kind_i     (kind),
    .rel_want_i (rel_want),
    .flags_i    (flags_t'(flags_i)),
    .hit_o      (hit)
  );

  bce_target_adder #(.PC_W(PC_W), .OFF_W(OFF_W)) u_add (
    .pc_i     (pc_i),
    .offset_i (offset_i),
    .target_o (target_calc)
  );

  always_comb begin
    taken_d  = eval_i & hit;
    target_d = eval_i ? target_calc : target_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      taken_q  <= 1'b0;
      target_q <= '0;
    end else begin
      taken_q  <= taken_d;
      target_q <= target_d;
    end
  end

  assign taken_o  = taken_q;
  assign target_o = target_q;

  // R8: a taken strobe needs an evaluation on the previous edge
  p_taken_needs_eval_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    taken_o |-> $past(eval_i));

  // R8: target held when nothing was evaluated
  p_target_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$past(eval_i) |-> $stable(target_o));

  // R6: taken only for a defined condition code
  p_unused_never_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    taken_o |-> ($past(cond_i) inside {4'b0000, 4'b0001, 4'b0010, 4'b0011,
                                       4'b0100, 4'b1000, 4'b1100, 4'b1111}));

  // R5: always-code evaluated gives a strobe
  p_always_taken_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(eval_i) && $past(cond_i) == 4'b1111) |-> taken_o);

  // R4: both-flags test needs overflow and carry
  p_vc_both_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (taken_o && $past(cond_i) == 4'b0011) |-> ($past(flags_i[1]) && $past(flags_i[0])));
endmodule

// File: tb/tb_bce_top.sv
module tb_bce_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        eval_i;
  logic [3:0]  flags_i;
  logic [3:0]  cond_i;
  logic [15:0] pc_i;
  logic [7:0]  offset_i;
  logic        taken_o;
  logic [15:0] target_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  bit          exp_taken = 0;
  logic [15:0] exp_target = 16'h0000;
  string       tag_taken = "R1";
  string       tag_target = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  bce_top dut (
    .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .flags_i(flags_i),
    .cond_i(cond_i), .pc_i(pc_i), .offset_i(offset_i),
    .taken_o(taken_o), .target_o(target_o)
  );

  function automatic bit ref_taken(input logic [3:0] c, input logic [3:0] f);
    int rel = f[3:2];
    case (c)
      4'b1000: return rel == 2;
      4'b0100: return rel == 1;
      4'b0000: return rel == 0;
      4'b1100: return (rel == 2) || (rel == 1);
      4'b0010: return f[1];
      4'b0001: return f[0];
      4'b0011: return f[1] && f[0];
      4'b1111: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string cond_tag(input logic [3:0] c);
    case (c)
      4'b1000, 4'b0100, 4'b0000: return "R2";
      4'b1100: return "R3";
      4'b0010, 4'b0001, 4'b0011: return "R4";
      4'b1111: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic compare_now();
    compared++;
    if (taken_o !== exp_taken) begin
      mismatched++;
      $display("FAIL %s taken actual=%0b expected=%0b", tag_taken, taken_o, exp_taken);
    end
    compared++;
    if (target_o !== exp_target) begin
      mismatched++;
      $display("FAIL %s target actual=%h expected=%h", tag_target, target_o, exp_target);
    end
  endtask

  // compare previous cycle's result, then apply new inputs
  task automatic step(input bit en, input logic [3:0] f, input logic [3:0] c,
                      input logic [15:0] pc, input logic [7:0] off);
    @(negedge clk);
    compare_now();
    eval_i = en; flags_i = f; cond_i = c; pc_i = pc; offset_i = off;
    if (en) begin
      exp_taken  = ref_taken(c, f);
      exp_target = pc + 16'd1 + {{8{off[7]}}, off};
      tag_taken  = cond_tag(c);
      tag_target = "R7";
    end else begin
      exp_taken  = 0;
      tag_taken  = "R8";
      tag_target = "R8";
    end
  endtask

  initial begin
    rst_n = 1'b0; eval_i = 0; flags_i = 4'hF; cond_i = 4'hF;
    pc_i = 16'h1234; offset_i = 8'h55;
    repeat (3) @(negedge clk);
    // R1: reset state while asserted
    compare_now();
    rst_n = 1'b1;
    // R1: stays in reset state through synchronizer release, idle
    for (int i = 0; i < 4; i++) step(0, 4'hF, 4'hF, 16'h1000 + 16'(i), 8'h7F);

    // R2..R6: all condition and flag pairings, idle cycles with noise between
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        step(1, 4'(f), 4'(c), 16'(c * 256 + f * 3), 8'(f * 17 + c));
        if (f % 4 == 3) step(0, 4'(~f), 4'hF, 16'hBEEF, 8'h80);  // R8
      end
    end

    // R7: address boundaries
    step(1, 4'h0, 4'hF, 16'hFFFF, 8'h00);
    step(1, 4'h0, 4'hF, 16'h0000, 8'h80);
    step(1, 4'h0, 4'hF, 16'h0010, 8'h7F);
    step(1, 4'h0, 4'hF, 16'hFFF0, 8'h7F);
    step(1, 4'h0, 4'hF, 16'h0005, 8'hFA);
    // R8: target held over several idle cycles with changing inputs
    for (int i = 0; i < 6; i++) step(0, 4'(i), 4'hF, 16'(i * 4111), 8'(i * 37));
    step(0, 4'h0, 4'h0, 16'h0, 8'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule